// File: doc/BRIEF.md
# Saturating Fractional Accumulator

This block holds a 40-bit signed accumulator for a fixed-point signal-processing datapath. Each accepted input beat carries a 32-bit signed fraction (1.31 format), which is widened by sign extension to the accumulator width. It is then added to or subtracted from the running total. The result passes through one of three overflow policies before it is registered. The narrow policy clamps at the 1.31 range. The wide policy clamps at the full 9.31 range. The wrap policy keeps the low 40 bits of the sum, so the sign may be lost.

Alongside the full accumulator the block drives a 16-bit readout of bits 31:16. This readout is rounded by the unbiased round-half-to-even rule and clamped so that it cannot roll over at the positive limit. It also drives two status bits. The first is a sticky flag, set by any clamp event and kept until software-side control pulses a clear. The second is a live indicator that the value no longer fits in 1.31.

The operand input is a valid/ready stream. `in_ready` is held high: one beat is consumed on every clock edge where `in_valid` is high, and the block never applies back-pressure. The mode selects, the accumulator clear and the flag clear are plain level controls sampled on the clock edge.

Top module: `dsp_sat_acc`

## Requirements
- R1: On a rising edge with `in_valid`=1 and `acc_clr`=0, `acc_q` becomes `acc_q` plus the sign-extended `op_data` (`op_sub`=0) or minus it (`op_sub`=1), subject to R4 to R6. `in_ready` is always 1.
- R2: With `in_valid`=0 and `acc_clr`=0, `acc_q` keeps its value, and so does `rnd_q`.
- R3: `acc_clr`=1 loads zero into `acc_q` at the next edge and takes priority over `in_valid`. It does not change `sat_flag`.
- R4: With `sat_en`=1 and `sat_wide`=0, a result above 0x00_7FFF_FFFF is replaced by 0x00_7FFF_FFFF, and a result below 0xFF_8000_0000 is replaced by 0xFF_8000_0000.
- R5: With `sat_en`=1 and `sat_wide`=1, a result above 0x7F_FFFF_FFFF is replaced by 0x7F_FFFF_FFFF, and a result below 0x80_0000_0000 is replaced by 0x80_0000_0000.
- R6: With `sat_en`=0, `acc_q` takes the low 40 bits of the exact sum, and no clamp occurs.
- R7: `sat_flag` goes to 1 on the edge after any clamp of R4 or R5 and stays 1 until an edge with `flag_clr`=1 and no clamp. If a clamp and `flag_clr` occur together, the flag is set.
- R8: `acc_ovf` is 1 exactly when `acc_q[39:31]` are not all equal.
- R9: `rnd_q` is `acc_q[31:16]` plus one when `acc_q[15:0]` is above 0x8000, or when it equals 0x8000 and `acc_q[16]` is 1. Otherwise it is `acc_q[31:16]` unchanged.
- R10: When R9 would increment 0x7FFF, `rnd_q` stays at 0x7FFF.
- R11: After reset (`rst_n`=0), `acc_q` is 0 and `sat_flag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand beat present |
| in_ready | output | 1 | Beat accepted; always 1 |
| op_data | input | 32 | Signed 1.31 operand |
| op_sub | input | 1 | 1 subtracts the operand, 0 adds it |
| sat_en | input | 1 | 1 enables clamping, 0 wraps |
| sat_wide | input | 1 | With `sat_en`, 1 clamps at 40 bits, 0 at 32 bits |
| acc_clr | input | 1 | Synchronous zeroing of the accumulator |
| flag_clr | input | 1 | Clears the sticky clamp flag |
| acc_q | output | 40 | Accumulator, signed 9.31 |
| rnd_q | output | 16 | Convergent-rounded 1.15 readout |
| sat_flag | output | 1 | Sticky clamp indicator |
| acc_ovf | output | 1 | Value outside 1.31 range |

## Verification
The properties assume that every control input holds a known 0 or 1 at each clock edge once reset is released. The mode selects are taken as they stand in the cycle of a beat, so a change of mode between beats is legal. The bench drives all inputs on the falling edge from a single task and leaves no signal undriven, which keeps within these assumptions. Its mode changes always fall between beats, so every beat sees one well-defined policy.

// File: rtl/dsp_acc_pkg.sv
package dsp_acc_pkg;
  typedef enum logic [1:0] {
    CLAMP_NONE   = 2'd0,
    CLAMP_NARROW = 2'd1,
    CLAMP_WIDE   = 2'd2
  } clamp_mode_e;

  function automatic clamp_mode_e decode_mode(input logic en, input logic wide);
    if (!en)       return CLAMP_NONE;
    else if (wide) return CLAMP_WIDE;
    else           return CLAMP_NARROW;
  endfunction
endpackage

// File: rtl/acc_addsub.sv
module acc_addsub #(
  parameter int ACC_W = 40,
  parameter int OP_W  = 32
) (
  input  logic [ACC_W-1:0] acc,
  input  logic [OP_W-1:0]  op,
  input  logic             sub,
  output logic [ACC_W:0]   sum
);
  localparam int EXT = ACC_W + 1 - OP_W;

  logic [ACC_W:0] op_ext;
  logic [ACC_W:0] acc_ext;

  always_comb begin
    op_ext  = {{EXT{op[OP_W-1]}}, op};
    acc_ext = {acc[ACC_W-1], acc};
    if (sub) sum = acc_ext - op_ext;
    else     sum = acc_ext + op_ext;
  end
endmodule

// File: rtl/acc_clamp.sv
module acc_clamp
  import dsp_acc_pkg::*;
#(
  parameter int ACC_W = 40,
  parameter int OP_W  = 32
) (
  input  logic [ACC_W:0]   sum,
  input  clamp_mode_e      mode,
  output logic [ACC_W-1:0] res,
  output logic             hit
);
  localparam int TOPN = ACC_W - OP_W + 2;
  localparam int GRD  = ACC_W - OP_W + 1;

  localparam logic [ACC_W-1:0] NAR_MAX = {{GRD{1'b0}}, {(OP_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] NAR_MIN = {{GRD{1'b1}}, {(OP_W-1){1'b0}}};
  localparam logic [ACC_W-1:0] WID_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] WID_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  logic [TOPN-1:0] top_bits;
  logic            nar_fit;
  logic            wid_fit;
  logic            neg;

  always_comb begin
    top_bits = sum[ACC_W:OP_W-1];
    nar_fit  = (&top_bits) || (~|top_bits);
    wid_fit  = (sum[ACC_W] == sum[ACC_W-1]);
    neg      = sum[ACC_W];
    res      = sum[ACC_W-1:0];
    hit      = 1'b0;
    unique case (mode)
      CLAMP_NARROW: if (!nar_fit) begin
        hit = 1'b1;
        res = neg ? NAR_MIN : NAR_MAX;
      end
      CLAMP_WIDE: if (!wid_fit) begin
        hit = 1'b1;
        res = neg ? WID_MIN : WID_MAX;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_round.sv
module acc_round #(
  parameter int ACC_W = 40,
  parameter int OP_W  = 32,
  parameter int OUT_W = 16
) (
  input  logic [ACC_W-1:0] acc,
  output logic [OUT_W-1:0] rnd
);
  localparam int LO = OP_W - OUT_W;
  localparam logic [LO-1:0]    HALF = {1'b1, {(LO-1){1'b0}}};
  localparam logic [OUT_W-1:0] PMAX = {1'b0, {(OUT_W-1){1'b1}}};

  logic [OUT_W-1:0] hi;
  logic [LO-1:0]    frac;
  logic             inc;

  always_comb begin
    hi   = acc[OP_W-1:LO];
    frac = acc[LO-1:0];
    inc  = (frac > HALF) || ((frac == HALF) && hi[0]);
    if (inc && (hi == PMAX)) rnd = PMAX;
    else                     rnd = hi + {{(OUT_W-1){1'b0}}, inc};
  end
endmodule

// File: rtl/dsp_sat_acc.sv
module dsp_sat_acc
  import dsp_acc_pkg::*;
#(
  parameter int ACC_W = 40,
  parameter int OP_W  = 32,
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [OP_W-1:0]  op_data,
  input  logic             op_sub,
  input  logic             sat_en,
  input  logic             sat_wide,
  input  logic             acc_clr,
  input  logic             flag_clr,
  output logic [ACC_W-1:0] acc_q,
  output logic [OUT_W-1:0] rnd_q,
  output logic             sat_flag,
  output logic             acc_ovf
);
  localparam int TOPN = ACC_W - OP_W + 1;

  logic [ACC_W:0]   sum;
  logic [ACC_W-1:0] next_acc;
  logic             clamp_hit;
  clamp_mode_e      mode;
  logic             take;

  assign in_ready = 1'b1;
  assign mode     = decode_mode(sat_en, sat_wide);
  assign take     = in_valid && !acc_clr;

  acc_addsub #(.ACC_W(ACC_W), .OP_W(OP_W)) addsub_i (
    .acc (acc_q),
    .op  (op_data),
    .sub (op_sub),
    .sum (sum)
  );

  acc_clamp #(.ACC_W(ACC_W), .OP_W(OP_W)) clamp_i (
    .sum  (sum),
    .mode (mode),
    .res  (next_acc),
    .hit  (clamp_hit)
  );

  acc_round #(.ACC_W(ACC_W), .OP_W(OP_W), .OUT_W(OUT_W)) round_i (
    .acc (acc_q),
    .rnd (rnd_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc_q <= '0;
    else if (acc_clr) acc_q <= '0;
    else if (take)    acc_q <= next_acc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  sat_flag <= 1'b0;
    else if (take && clamp_hit)  sat_flag <= 1'b1;
    else if (flag_clr)           sat_flag <= 1'b0;
  end

  logic [TOPN-1:0] top_bits;
  assign top_bits = acc_q[ACC_W-1:OP_W-1];
  assign acc_ovf  = !((&top_bits) || (~|top_bits));
endmodule

// File: rtl/dsp_sat_acc_chk.sv
module dsp_sat_acc_chk #(
  parameter int ACC_W = 40,
  parameter int OP_W  = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [OP_W-1:0]  op_data,
  input logic             op_sub,
  input logic             sat_en,
  input logic             sat_wide,
  input logic             acc_clr,
  input logic             flag_clr,
  input logic [ACC_W-1:0] acc_q,
  input logic             sat_flag,
  input logic             acc_ovf
);
  AST_ALWAYS_READY: assert property (@(posedge clk) disable iff (!rst_n) in_ready); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !acc_clr) |=> $stable(acc_q)); // R2
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    acc_clr |=> (acc_q == '0)); // R3
  AST_NARROW_FIT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !acc_clr && sat_en && !sat_wide) |=> !acc_ovf); // R4
  AST_WIDE_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !acc_clr && sat_en && sat_wide && !op_sub && !op_data[OP_W-1] && !acc_q[ACC_W-1])
    |=> !acc_q[ACC_W-1]); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_flag && !flag_clr) |=> sat_flag); // R7
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !in_valid) |=> !sat_flag); // R7
  AST_FLAG_ON_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_clr && !flag_clr) |=> $stable(sat_flag)); // R3
endmodule

bind dsp_sat_acc dsp_sat_acc_chk #(.ACC_W(ACC_W), .OP_W(OP_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .op_data  (op_data),
  .op_sub   (op_sub),
  .sat_en   (sat_en),
  .sat_wide (sat_wide),
  .acc_clr  (acc_clr),
  .flag_clr (flag_clr),
  .acc_q    (acc_q),
  .sat_flag (sat_flag),
  .acc_ovf  (acc_ovf)
);

// File: tb/dsp_sat_acc_tb_top.sv
module dsp_sat_acc_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] op_data = '0;
  logic        op_sub = 1'b0;
  logic        sat_en = 1'b0;
  logic        sat_wide = 1'b0;
  logic        acc_clr = 1'b0;
  logic        flag_clr = 1'b0;
  logic [39:0] acc_q;
  logic [15:0] rnd_q;
  logic        sat_flag;
  logic        acc_ovf;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  dsp_sat_acc dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_data(op_data), .op_sub(op_sub), .sat_en(sat_en), .sat_wide(sat_wide),
    .acc_clr(acc_clr), .flag_clr(flag_clr), .acc_q(acc_q), .rnd_q(rnd_q),
    .sat_flag(sat_flag), .acc_ovf(acc_ovf)
  );

  typedef struct packed {
    logic        clr, vld, sub, en, wide, fclr;
    logic [31:0] op;
    logic [39:0] acc;
    logic [15:0] rnd;
    logic        flg;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0000_0000, 40'h00_0000_0000, 16'h0000, 1'b0}, // R3
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0, 32'h0000_1000, 40'h00_0000_1000, 16'h0000, 1'b0}, // R1
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0, 32'h7FFF_F000, 40'h00_7FFF_FFFF, 16'h7FFF, 1'b1}, // R4 R10
    '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0, 32'hFFFF_FFFF, 40'h00_7FFF_FFFF, 16'h7FFF, 1'b1}, // R4
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0, 32'h8000_0000, 40'hFF_FFFF_FFFF, 16'h0000, 1'b1}, // R1 R9
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0, 32'h8000_0000, 40'hFF_8000_0000, 16'h8000, 1'b1}, // R4
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b1, 32'h1234_5678, 40'h00_0000_0000, 16'h0000, 1'b0}, // R3 R7
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b0, 32'h7FFF_FFFF, 40'h00_7FFF_FFFF, 16'h7FFF, 1'b0}, // R5
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b0, 32'h7FFF_FFFF, 40'h00_FFFF_FFFE, 16'h0000, 1'b0}, // R5 R8
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0000_0000, 40'h00_0000_0000, 16'h0000, 1'b0},
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 32'h7FFF_FFFF, 40'h00_7FFF_FFFF, 16'h7FFF, 1'b0}, // R6
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 32'h0000_0001, 40'h00_8000_0000, 16'h8000, 1'b0}, // R6 R8
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0000_0005, 40'h00_8000_0000, 16'h8000, 1'b0}, // R2
    '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0, 32'h0000_0001, 40'h00_7FFF_FFFF, 16'h7FFF, 1'b0}, // R4 no clamp
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0000_0000, 40'h00_0000_0000, 16'h0000, 1'b0},
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 32'h0001_8000, 40'h00_0001_8000, 16'h0002, 1'b0}, // R9 odd half
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0000_0000, 40'h00_0000_0000, 16'h0000, 1'b0},
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 32'h0000_8000, 40'h00_0000_8000, 16'h0000, 1'b0}, // R9 even half
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 32'h0000_0001, 40'h00_0000_8001, 16'h0001, 1'b0}, // R9 above half
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0000_0000, 40'h00_0000_0000, 16'h0000, 1'b0},
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 32'h7FFF_8000, 40'h00_7FFF_8000, 16'h7FFF, 1'b0}, // R10
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0000_0000, 40'h00_0000_0000, 16'h0000, 1'b0},
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 32'hFFFF_8000, 40'hFF_FFFF_8000, 16'h0000, 1'b0}, // R9 negative
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0000_0000, 40'h00_0000_0000, 16'h0000, 1'b0},
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 32'h0002_8000, 40'h00_0002_8000, 16'h0002, 1'b0}  // R9 even half
  };

  task automatic chk(input string req, input string what, input logic [39:0] act, input logic [39:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic clr, input logic vld, input logic sub, input logic en,
                       input logic wide, input logic fclr, input logic [31:0] op);
    @(negedge clk);
    acc_clr = clr; in_valid = vld; op_sub = sub; sat_en = en;
    sat_wide = wide; flag_clr = fclr; op_data = op;
    @(posedge clk);
    #(CLK_P/4);
  endtask

  task automatic idle();
    apply(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
  endtask

  function automatic logic exp_ovf(input logic [39:0] a);
    return !((a[39:31] == 9'h000) || (a[39:31] == 9'h1FF));
  endfunction

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #(CLK_P/4);
    // R11 reset state
    chk("R11", "acc", acc_q, 40'h0);
    chk("R11", "flag", {39'h0, sat_flag}, 40'h0);
    chk("R9", "rnd at reset", {24'h0, rnd_q}, 40'h0);
    chk("R1", "ready", {39'h0, in_ready}, 40'h1);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].clr, VECS[i].vld, VECS[i].sub, VECS[i].en, VECS[i].wide, VECS[i].fclr, VECS[i].op);
      chk("R1/R4/R5/R6", $sformatf("vec %0d acc", i), acc_q, VECS[i].acc);
      chk("R9/R10", $sformatf("vec %0d rnd", i), {24'h0, rnd_q}, {24'h0, VECS[i].rnd});
      chk("R7", $sformatf("vec %0d flag", i), {39'h0, sat_flag}, {39'h0, VECS[i].flg});
      chk("R8", $sformatf("vec %0d ovf", i), {39'h0, acc_ovf}, {39'h0, exp_ovf(VECS[i].acc)});
    end

    // R7: clamp and flag clear in the same cycle -> set wins
    apply(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0);
    apply(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 32'h7FFF_FFFF);
    apply(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 32'h7FFF_FFFF);
    chk("R7", "set wins over clear", {39'h0, sat_flag}, 40'h1);
    idle();
    chk("R7", "flag held", {39'h0, sat_flag}, 40'h1);
    // R3: accumulator clear leaves flag alone
    apply(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
    chk("R3", "clr keeps flag", {39'h0, sat_flag}, 40'h1);
    chk("R3", "clr zeroes acc", acc_q, 40'h0);
    apply(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0);
    chk("R7", "flag cleared", {39'h0, sat_flag}, 40'h0);

    // R5: positive wide clamp after many beats
    for (int k = 0; k < 260; k++)
      apply(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 32'h7FFF_FFFF);
    chk("R5", "wide max", acc_q, 40'h7F_FFFF_FFFF);
    chk("R7", "wide clamp flag", {39'h0, sat_flag}, 40'h1);
    chk("R8", "ovf at wide max", {39'h0, acc_ovf}, 40'h1);
    apply(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0);
    // R6: wrap destroys sign, no flag
    apply(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_0001);
    chk("R6", "wrap to negative", acc_q, 40'h80_0000_0000);
    chk("R6", "wrap sets no flag", {39'h0, sat_flag}, 40'h0);
    // R5: negative wide clamp
    apply(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 32'h8000_0000);
    chk("R5", "wide min", acc_q, 40'h80_0000_0000);
    chk("R7", "neg wide flag", {39'h0, sat_flag}, 40'h1);
    // R4: narrow clamp of an out-of-range value pulls it to the 1.31 floor
    apply(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_0000);
    chk("R4", "narrow from wide neg", acc_q, 40'hFF_8000_0000);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule